// File: doc/BRIEF.md
# Multiplexed Bus Target Responder

This block answers cycles on a shared, synchronous, multiplexed address/data bus as a slave. It watches for the start of a cycle, captures the address and command, and decides whether the cycle is meant for it. Two local windows can be reached: a memory window that supports bursts, and a small I/O window that moves single words. When the block claims a cycle, it moves one 32-bit word on every clock edge where the initiator and the target are both ready. Writes are merged byte by byte under the byte enables.

Termination is chosen by the target. A local busy request forces a retry, which stops the cycle before any data moves. A burst that would leave its window, or an I/O access that asks for more than one word, is disconnected after the last word it is allowed. A separate local wait request holds off target readiness and so adds wait states. The bus is split into input and output halves (`ad_i`, `ad_o`, `ad_oe`) so that the pad ring can build the shared bidirectional lines. Every control pin is active low.

Top module: `bt_target`

## Requirements
- R1: While reset is held, and after it is released, the claim, ready and stop outputs are high and `ad_oe` is low.
- R2: The address is captured on the edge where `frame_n` is low and `irdy_n` is high, and the command comes from `cbe_n` on that edge. For a supported command that hits a window, `devsel_n` goes low after the second rising edge that follows the last address phase. Memory commands are 0110, 0111, 1100, 1110 and 1111. I/O commands are 0010 and 0011. The write commands are 0011, 0111 and 1111.
- R3: An address outside both windows, an unsupported command, or an I/O command aimed at the memory window is never claimed. `devsel_n` stays high for the whole cycle.
- R4: A word moves only on an edge where `irdy_n` and `trdy_n` are both low. `trdy_n` never falls on an edge where `wait_req` is high. Once `trdy_n` is low, it stays low until a word moves.
- R5: On a write, only the byte lanes whose `cbe_n` bit is 0 in that data phase are updated. Bit k controls bits 8k+7..8k.
- R6: A memory burst reads or writes consecutive words, starting at the captured word address. Read data appears on `ad_o` for each word.
- R7: If `retry_req` is high on the edge after the address phase, the block claims the cycle and asserts `stop_n` without `trdy_n`. No data moves and the storage is unchanged.
- R8: A memory burst that reaches the last word of its window is disconnected. `stop_n` is asserted after the last in-window word, and no further word moves.
- R9: An I/O access moves at most one word. If the initiator asks for more, `stop_n` is asserted after the first word.
- R10: A dual-address cycle (first command 1101) takes a second address phase that carries the upper 32 bits and the real command. It is claimed only if the upper bits are zero and the real command is a memory command that hits the memory window.
- R11: `ad_oe` is high only during claimed read cycles while `devsel_n` is low. On the edge that ends the cycle, `devsel_n`, `trdy_n`, `stop_n` and `ad_oe` all return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Cycle in progress, from the initiator |
| irdy_n | input | 1 | Initiator ready |
| cbe_n | input | 4 | Command in the address phase; active-low byte enables in data phases |
| ad_i | input | 32 | Address/data bus, input half |
| ad_o | output | 32 | Read data toward the bus |
| ad_oe | output | 1 | Drive enable for `ad_o` |
| devsel_n | output | 1 | Cycle claimed |
| trdy_n | output | 1 | Target ready |
| stop_n | output | 1 | Target termination request |
| retry_req | input | 1 | Local busy: forces a retry on the next claim |
| wait_req | input | 1 | Local hold: delays target readiness |

## Verification
The hardest case to reach from the ports is a disconnect at the window boundary that coincides with initiator wait states and local hold cycles. In that case, the edge that moves the last word, the edge that raises `stop_n`, and the initiator's late `frame_n` release all depend on one another. The stimulus starts bursts close to the last word of each window and asks for more words than remain. The initiator randomly inserts `irdy_n` wait cycles and `wait_req` is toggled at random every cycle, so the boundary beat lands after a varying number of stalls. Dual-address cycles and retries are mixed into the same random stream.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam logic [3:0] CMD_IO_RD   = 4'b0010;
  localparam logic [3:0] CMD_IO_WR   = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [3:0] CMD_RD_MULT = 4'b1100;
  localparam logic [3:0] CMD_DUAL    = 4'b1101;
  localparam logic [3:0] CMD_RD_LINE = 4'b1110;
  localparam logic [3:0] CMD_WR_INV  = 4'b1111;

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR2, ST_DEC, ST_DATA, ST_SKIP} tgt_state_e;

  function automatic logic cmd_is_mem(logic [3:0] c);
    return (c == CMD_MEM_RD) || (c == CMD_MEM_WR) || (c == CMD_RD_MULT) ||
           (c == CMD_RD_LINE) || (c == CMD_WR_INV);
  endfunction

  function automatic logic cmd_is_io(logic [3:0] c);
    return (c == CMD_IO_RD) || (c == CMD_IO_WR);
  endfunction

  function automatic logic cmd_is_write(logic [3:0] c);
    return (c == CMD_IO_WR) || (c == CMD_MEM_WR) || (c == CMD_WR_INV);
  endfunction

  // word distance of a word address from a byte-aligned base
  function automatic logic [29:0] word_dist(logic [29:0] w, logic [31:0] base);
    return w - base[31:2];
  endfunction
endpackage

// File: rtl/bt_decode.sv
module bt_decode import bt_pkg::*; #(
  parameter logic [31:0] MEM_BASE  = 32'h0000_1000,
  parameter int          MEM_WORDS = 16,
  parameter logic [31:0] IO_BASE   = 32'h0000_0100,
  parameter int          IO_WORDS  = 4,
  parameter int          OFF_W     = 5
) (
  input  logic [29:0]      word_addr,
  input  logic [31:0]      upper,
  input  logic [3:0]       cmd,
  input  logic             dual,
  output logic             hit,
  output logic             is_io,
  output logic             is_wr,
  output logic [OFF_W-1:0] off
);
  logic [29:0] mem_d, io_d;
  logic        mem_ok, io_ok;

  always_comb begin
    mem_d  = word_dist(word_addr, MEM_BASE);
    io_d   = word_dist(word_addr, IO_BASE);
    mem_ok = cmd_is_mem(cmd) && (mem_d < 30'(MEM_WORDS)) && (upper == '0);
    io_ok  = cmd_is_io(cmd) && (io_d < 30'(IO_WORDS)) && !dual;
    hit    = mem_ok || io_ok;
    is_io  = io_ok;
    is_wr  = cmd_is_write(cmd);
    off    = io_ok ? io_d[OFF_W-1:0] : mem_d[OFF_W-1:0];
  end
endmodule

// File: rtl/bt_store.sv
module bt_store #(
  parameter int DEPTH = 20,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  input  logic [3:0]       wbe,
  input  logic [IDX_W-1:0] ridx,
  output logic [31:0]      rdata
);
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] lane [DEPTH];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < DEPTH; k++) lane[k] <= '0;
      end else if (we && wbe[g] && (widx < IDX_W'(DEPTH))) begin
        lane[widx] <= wdata[8*g +: 8];
      end
    end
    assign rdata[8*g +: 8] = (ridx < IDX_W'(DEPTH)) ? lane[ridx] : 8'h00;
  end
endmodule

// File: rtl/bt_target.sv
module bt_target import bt_pkg::*; #(
  parameter logic [31:0] MEM_BASE  = 32'h0000_1000,
  parameter int          MEM_WORDS = 16,
  parameter logic [31:0] IO_BASE   = 32'h0000_0100,
  parameter int          IO_WORDS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_i,
  output logic [31:0] ad_o,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n,
  input  logic        retry_req,
  input  logic        wait_req
);
  localparam int BIG   = (MEM_WORDS > IO_WORDS) ? MEM_WORDS : IO_WORDS;
  localparam int OFF_W = $clog2(BIG + 1);
  localparam int DEPTH = MEM_WORDS + IO_WORDS;
  localparam int IDX_W = $clog2(DEPTH + 1);

  function automatic logic [IDX_W-1:0] flat_idx(logic io, logic [OFF_W-1:0] o);
    return io ? IDX_W'(MEM_WORDS) + IDX_W'(o) : IDX_W'(o);
  endfunction

  tgt_state_e       state;
  logic [29:0]      lat_word;
  logic [31:0]      lat_upper;
  logic [3:0]       lat_cmd;
  logic             lat_dual;
  logic [OFF_W-1:0] cur_off;
  logic             cur_io, cur_wr;

  // named events for the checker
  logic             addr_ph, in_dec, beat_ev, done_ev, cut_ev, at_edge;
  logic             dec_hit, dec_io, dec_wr;
  logic [OFF_W-1:0] dec_off, off_nx;
  logic [IDX_W-1:0] rd_idx;
  logic [31:0]      rdata;

  bt_decode #(.MEM_BASE(MEM_BASE), .MEM_WORDS(MEM_WORDS), .IO_BASE(IO_BASE),
              .IO_WORDS(IO_WORDS), .OFF_W(OFF_W)) u_dec (
    .word_addr(lat_word), .upper(lat_upper), .cmd(lat_cmd), .dual(lat_dual),
    .hit(dec_hit), .is_io(dec_io), .is_wr(dec_wr), .off(dec_off));

  always_comb begin
    addr_ph = (state == ST_IDLE) && !frame_n && irdy_n;
    in_dec  = (state == ST_DEC);
    beat_ev = (state == ST_DATA) && !irdy_n && !trdy_n;
    done_ev = (state == ST_DATA) && frame_n && !irdy_n && (!trdy_n || !stop_n);
    off_nx  = cur_off + OFF_W'(beat_ev);
    at_edge = off_nx == (cur_io ? OFF_W'(IO_WORDS) : OFF_W'(MEM_WORDS));
    cut_ev  = beat_ev && !frame_n && (cur_io || at_edge);
    rd_idx  = in_dec ? flat_idx(dec_io, dec_off) : flat_idx(cur_io, off_nx);
  end

  bt_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(beat_ev && cur_wr),
    .widx(flat_idx(cur_io, cur_off)), .wdata(ad_i), .wbe(~cbe_n),
    .ridx(rd_idx), .rdata(rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_word  <= '0;
      lat_upper <= '0;
      lat_cmd   <= '0;
      lat_dual  <= 1'b0;
      cur_off   <= '0;
      cur_io    <= 1'b0;
      cur_wr    <= 1'b0;
      devsel_n  <= 1'b1;
      trdy_n    <= 1'b1;
      stop_n    <= 1'b1;
      ad_oe     <= 1'b0;
      ad_o      <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (addr_ph) begin
          lat_word  <= ad_i[31:2];
          lat_cmd   <= cbe_n;
          lat_upper <= '0;
          lat_dual  <= (cbe_n == CMD_DUAL);
          state     <= (cbe_n == CMD_DUAL) ? ST_ADDR2 : ST_DEC;
        end
        ST_ADDR2: begin
          lat_upper <= ad_i;
          lat_cmd   <= cbe_n;
          state     <= ST_DEC;
        end
        ST_DEC: begin
          if (dec_hit) begin
            state    <= ST_DATA;
            cur_off  <= dec_off;
            cur_io   <= dec_io;
            cur_wr   <= dec_wr;
            devsel_n <= 1'b0;
            stop_n   <= !retry_req;
            trdy_n   <= retry_req || wait_req;
            ad_oe    <= !dec_wr;
            ad_o     <= rdata;
          end else begin
            state <= ST_SKIP;
          end
        end
        ST_DATA: begin
          if (done_ev) begin
            state    <= ST_IDLE;
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            stop_n   <= 1'b1;
            ad_oe    <= 1'b0;
          end else begin
            cur_off <= off_nx;
            ad_o    <= rdata;
            if (!stop_n || cut_ev) begin
              stop_n <= 1'b0;
              trdy_n <= 1'b1;
            end else if (!trdy_n && !beat_ev) begin
              trdy_n <= 1'b0;
            end else begin
              trdy_n <= wait_req;
            end
          end
        end
        ST_SKIP: if (frame_n && irdy_n) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bt_target_chk.sv
module bt_target_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_n,
  input logic devsel_n,
  input logic trdy_n,
  input logic stop_n,
  input logic ad_oe,
  input logic retry_req,
  input logic in_dec,
  input logic dec_hit,
  input logic beat_ev,
  input logic done_ev,
  input logic cur_io
);
  a_r4_ready_needs_claim: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

  a_r11_drive_needs_claim: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !devsel_n);

  a_r2_claim_after_decode: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(in_dec));

  a_r7_retry_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dec && dec_hit && retry_req) |=> (!devsel_n && !stop_n && trdy_n));

  a_r9_io_one_word: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ev && cur_io && !frame_n) |=> (!stop_n && trdy_n));

  a_r4_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !beat_ev && !done_ev) |=> !trdy_n);

  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> (devsel_n && trdy_n && stop_n && !ad_oe));
endmodule

bind bt_target bt_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .devsel_n(devsel_n),
  .trdy_n(trdy_n), .stop_n(stop_n), .ad_oe(ad_oe), .retry_req(retry_req),
  .in_dec(in_dec), .dec_hit(dec_hit), .beat_ev(beat_ev), .done_ev(done_ev),
  .cur_io(cur_io));

// File: tb/sim_bt_target.sv
module sim_bt_target;
  localparam logic [31:0] MB = 32'h0000_1000;
  localparam logic [31:0] IB = 32'h0000_0100;
  localparam int MW = 16;
  localparam int IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, retry_req = 1'b0, wait_req = 1'b0;
  logic [3:0] cbe_n = '0;
  logic [31:0] ad_i = '0, ad_o;
  logic ad_oe, devsel_n, trdy_n, stop_n;

  bt_target u0 (.clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .retry_req(retry_req), .wait_req(wait_req));

  always #2 clk = ~clk;

  int total = 0, passed = 0, wait_pct = 0, nb;
  logic [31:0] mref [MW];
  logic [31:0] iref [IW];
  logic [31:0] wd [16];
  logic [3:0]  wb [16];
  logic [31:0] last_rd;

  task automatic report();
    $display("%0d/%0d checks passed", passed, total);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  function automatic bit is_memc(logic [3:0] c);
    return c inside {4'h6, 4'h7, 4'hC, 4'hE, 4'hF};
  endfunction
  function automatic bit is_ioc(logic [3:0] c);
    return c inside {4'h2, 4'h3};
  endfunction
  function automatic bit is_wrc(logic [3:0] c);
    return c inside {4'h3, 4'h7, 4'hF};
  endfunction

  function automatic bit exp_target(input logic [3:0] c, input logic [31:0] a,
      input logic [31:0] up, input bit dual, output bit io, output int off);
    io = 0; off = 0;
    if (is_memc(c) && up == 0 && a >= MB && a < MB + 4*MW) begin
      off = int'((a - MB) >> 2); return 1;
    end
    if (is_ioc(c) && !dual && a >= IB && a < IB + 4*IW) begin
      io = 1; off = int'((a - IB) >> 2); return 1;
    end
    return 0;
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] ben);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (!ben[k]) r[8*k +: 8] = nw[8*k +: 8];
    return r;
  endfunction

  task automatic xfer(input logic [3:0] c, input logic [31:0] a, input logic [31:0] up,
      input bit dual, input int n, input bit rty, input string tag, output int got);
    bit hit, io, wr, claimed, ended, abort, b, hold_prev, prev_trdy;
    int off, cyc, i, exp_nb, dsl_at, hold_bad, oe_bad, idx;
    logic [31:0] m;
    hit = exp_target(c, a, up, dual, io, off);
    wr = is_wrc(c);
    exp_nb = (!hit || rty) ? 0 : (io ? 1 : MW - off);
    if (exp_nb > n) exp_nb = n;
    retry_req = rty;
    @(negedge clk); frame_n = 0; irdy_n = 1; ad_i = a; cbe_n = dual ? 4'hD : c;
    if (dual) begin @(negedge clk); ad_i = up; cbe_n = c; end
    @(negedge clk); i = 0; ad_i = wd[0]; cbe_n = wb[0]; irdy_n = 0; frame_n = (n == 1);
    got = 0; cyc = 0; claimed = 0; dsl_at = 0; hold_bad = 0; oe_bad = 0;
    hold_prev = 0; prev_trdy = 1; ended = 0; abort = 0;
    while (!ended && cyc < 100) begin
      cyc++;
      if (!devsel_n && !claimed) begin claimed = 1; dsl_at = cyc; end
      if (prev_trdy && !trdy_n && hold_prev) hold_bad++;
      if (!stop_n && !frame_n) begin frame_n = 1; irdy_n = 0; end
      if (!claimed && cyc > 5) begin frame_n = 1; irdy_n = 0; abort = 1; end
      b = !irdy_n && !trdy_n;
      if (b) begin
        idx = off + got;
        m = io ? (idx < IW ? iref[idx] : 'x) : (idx < MW ? mref[idx] : 'x);
        if (wr) begin
          if (ad_oe) oe_bad++;
          if (io && idx < IW) iref[idx] = merge(m, ad_i, cbe_n);
          else if (!io && idx < MW) mref[idx] = merge(m, ad_i, cbe_n);
        end else begin
          if (!ad_oe) oe_bad++;
          last_rd = ad_o;
          chk(ad_o === m, "R6 read data", ad_o, m);
        end
        got++;
      end
      ended = abort || (frame_n && !irdy_n && (!trdy_n || !stop_n));
      prev_trdy = trdy_n;
      wait_req = ($urandom % 100) < wait_pct;
      hold_prev = wait_req;
      @(negedge clk);
      if (!ended) begin
        if (b) begin
          i++; ad_i = wd[i]; cbe_n = wb[i]; frame_n = (i >= n - 1);
          irdy_n = !frame_n && ($urandom % 4 == 0);
        end else irdy_n = 0;
      end
    end
    wait_req = 0; retry_req = 0;
    if (cyc >= 100) chk(0, "R4 cycle ended", cyc, 0);
    if (claimed) chk(devsel_n && trdy_n && stop_n && !ad_oe, "R11 release",
                     {ad_oe, stop_n, trdy_n, devsel_n}, 32'h7);
    frame_n = 1; irdy_n = 1; ad_i = '0; cbe_n = '0;
    chk(claimed == hit, hit ? "R2 claim" : "R3 no claim", claimed, hit);
    if (hit) chk(dsl_at == 2, "R2 claim timing", dsl_at, 2);
    chk(got == exp_nb, tag, got, exp_nb);
    chk(hold_bad == 0, "R4 wait states honoured", hold_bad, 0);
    chk(oe_bad == 0, "R11 read drive", oe_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    logic [3:0] cl [10];
    void'($urandom(1234));
    cl = '{4'h2, 4'h3, 4'h6, 4'h7, 4'hC, 4'hE, 4'hF, 4'h4, 4'hA, 4'h1};
    for (int k = 0; k < MW; k++) mref[k] = '0;
    for (int k = 0; k < IW; k++) iref[k] = '0;
    repeat (3) @(negedge clk);
    chk(devsel_n && trdy_n && stop_n && !ad_oe, "R1 reset state",
        {ad_oe, stop_n, trdy_n, devsel_n}, 32'h7);
    rst_n = 1;
    @(negedge clk);
    chk(devsel_n && trdy_n && stop_n && !ad_oe, "R1 after reset",
        {ad_oe, stop_n, trdy_n, devsel_n}, 32'h7);

    for (int k = 0; k < 16; k++) begin wd[k] = $urandom; wb[k] = 4'h0; end
    xfer(4'h7, MB, 0, 0, 16, 0, "R6 full window burst write", nb);
    for (int k = 0; k < IW; k++) begin
      wd[0] = $urandom; xfer(4'h3, IB + 4*k, 0, 0, 1, 0, "R9 single io write", nb);
    end
    xfer(4'hC, MB + 8, 0, 0, 4, 0, "R6 burst read", nb);
    xfer(4'h6, MB + 4*14, 0, 0, 4, 0, "R8 read boundary disconnect", nb);
    xfer(4'h7, MB + 4*15, 0, 0, 3, 0, "R8 write boundary disconnect", nb);
    xfer(4'h2, IB + 4, 0, 0, 3, 0, "R9 io read disconnect", nb);
    xfer(4'h3, IB, 0, 0, 3, 0, "R9 io write disconnect", nb);

    wd[0] = 32'hFFFF_FFFF; wb[0] = 4'h0;
    xfer(4'h7, MB + 20, 0, 0, 1, 0, "R5 full write", nb);
    wd[0] = 32'h1122_3344; wb[0] = 4'b1010;
    xfer(4'h7, MB + 20, 0, 0, 1, 0, "R5 partial write", nb);
    wb[0] = 4'h0;
    xfer(4'h6, MB + 20, 0, 0, 1, 0, "R5 read back", nb);
    chk(last_rd == 32'hFF22_FF44, "R5 byte lanes", last_rd, 32'hFF22_FF44);

    wd[0] = 32'hDEAD_BEEF;
    xfer(4'h7, MB + 12, 0, 0, 2, 1, "R7 retry moves nothing", nb);
    xfer(4'h6, MB + 12, 0, 0, 1, 0, "R7 storage unchanged", nb);

    wd[0] = 32'hA5A5_0F0F; wd[1] = 32'h1234_5678;
    xfer(4'h7, MB + 4, 0, 1, 2, 0, "R10 dual address write", nb);
    xfer(4'hE, MB + 4, 0, 1, 2, 0, "R10 dual address read", nb);
    xfer(4'h6, MB + 4, 32'h1, 1, 2, 0, "R10 nonzero upper ignored", nb);
    xfer(4'h6, MB + 4, 0, 0, 1, 0, "R10 storage after ignored", nb);

    xfer(4'hA, MB, 0, 0, 1, 0, "R3 unsupported command", nb);
    xfer(4'h6, MB + 4*MW, 0, 0, 2, 0, "R3 outside window", nb);
    xfer(4'h2, MB, 0, 0, 1, 0, "R3 io command at memory", nb);

    wait_pct = 60;
    xfer(4'h6, MB, 0, 0, 5, 0, "R4 beats under wait states", nb);

    for (int t = 0; t < 80; t++) begin
      logic [3:0] c;
      logic [31:0] a, up;
      bit dual, rty, io;
      int n, off, sel;
      c = cl[$urandom % 10];
      sel = $urandom % 5;
      a = (sel < 2) ? MB + 4*($urandom % MW) : (sel < 4) ? IB + 4*($urandom % IW)
                    : 32'h8000_0000 | ($urandom & 32'hFFFC);
      dual = ($urandom % 7) == 0;
      up = (dual && ($urandom % 2)) ? ($urandom | 32'h1) : 32'h0;
      n = 1 + $urandom % 5;
      rty = ($urandom % 10) == 0;
      wait_pct = $urandom % 50;
      for (int k = 0; k < 16; k++) begin wd[k] = $urandom; wb[k] = 4'($urandom); end
      if (exp_target(c, a, up, dual, io, off))
        xfer(c, a, up, dual, n, rty, rty ? "R7 random retry" : io ? "R9 random io" : "R8 random burst", nb);
      else
        xfer(c, a, up, dual, n, rty, "R3 random unclaimed", nb);
    end
    report();
    $finish;
  end
endmodule